// File: doc/BRIEF.md
# Receive Character Queue with Trigger-Level Flow Control

This block sits between a serial receiver and the host read port. It stores up to 16 received characters. Each entry holds a data byte and three error flags. Reads are show-ahead: the oldest entry is always present on the read outputs, and a read strobe pops it.

The fill level is compared with a programmable trigger threshold. Reaching the threshold does three things:
- It drops the ready-to-send output, so the far end holds off.
- It raises a one-cycle DMA request pulse.
- It still leaves room for characters that were already in flight.

A character-time timeout covers data that is left waiting below the threshold. When it fires it raises a timeout flag and also a DMA request pulse. The timeout length follows the configured word length. An overrun flag records any character that arrived while the queue was full. A clear input empties the queue in a single cycle.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, `empty`=1, `rts`=1, `dma_req`=0, `timeout`=0 and `overrun`=0.
- R2: Entries leave in arrival order. Each read returns the written byte on `rd_data` and its three error flags on `rd_err`. The oldest entry is shown on these outputs before the read strobe.
- R3: `trig_sel` selects the threshold: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters. `rts` is 0 exactly when the stored count is at or above the threshold.
- R4: `rts` returns to 1 as soon as a read brings the count below the threshold.
- R5: When a write brings the count up to the threshold, `dma_req` is 1 for exactly one cycle, in the cycle after that write.
- R6: Writes are still accepted after `rts` has dropped, up to 16 stored characters, and they read back intact.
- R7: A write while 16 characters are stored is discarded and sets `overrun`. `overrun` stays set until `fifo_clr`.
- R8: `empty` is 1 exactly when no character is stored. A read while empty has no effect.
- R9: `timeout` rises on the 4*(D+2)-th `bit_tick` seen while the queue is non-empty with no read and no write. D is the data width given by `word_len`: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8 bits. `timeout` never rises while the queue is empty.
- R10: A rising `timeout` gives a one-cycle `dma_req` pulse in the same cycle.
- R11: Any accepted read or write clears `timeout` and restarts the tick count.
- R12: `fifo_clr` empties the queue and clears `overrun`, `timeout` and the tick count in one cycle. It takes precedence over a simultaneous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Received byte |
| wr_err | input | 3 | Error flags of the received byte |
| rd_en | input | 1 | Host pops the oldest entry |
| rd_data | output | 8 | Byte of the oldest entry |
| rd_err | output | 3 | Error flags of the oldest entry |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14) |
| word_len | input | 2 | Data width select (5 to 8 bits) |
| bit_tick | input | 1 | One pulse per serial bit time |
| fifo_clr | input | 1 | Empty the queue and clear flags |
| rts | output | 1 | Ready to send; low at or above threshold |
| dma_req | output | 1 | One-cycle receive request pulse |
| timeout | output | 1 | Stale data below threshold |
| empty | output | 1 | No character stored |
| overrun | output | 1 | Sticky: a character was dropped |

## Verification
Several relations between outputs are checked by assertions on every cycle:
- `rts` is high whenever the queue is empty.
- `timeout` is never set while the queue is empty.
- A falling `rts` always comes with a `dma_req` pulse.
- `overrun` stays set until a clear.
- A clear or any traffic removes the timeout one cycle later.

Other behaviour can only be shown by the bench's scenarios. These include arrival order with error flags, the exact threshold for each select value, and the extra characters taken in after `rts` drops. They also include the exact tick count at which the timeout fires for each word length.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;
    localparam int TICK_W = 6;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    // threshold in characters for each select code
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    // four character times: start + data + stop bits, times four
    function automatic logic [TICK_W-1:0] idle_limit(input logic [1:0] wl);
        int unsigned bits;
        bits = 5 + int'(wl) + 2;
        return TICK_W'(4 * bits);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  rxq_entry_t    din,
    output rxq_entry_t    dout,
    output logic [CW-1:0] count,
    output logic          lost
);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, is_empty, push_ok, pop_ok;

    assign full     = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !is_empty;
    assign dout     = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            lost  <= 1'b0;
        end else begin
            if (push_ok)
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) lost <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              activity,
    input  logic              idle_empty,
    input  logic              tick,
    input  logic [TICK_W-1:0] limit,
    output logic              expired
);

    logic [TICK_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || activity || idle_empty) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            if (cnt == limit - 1'b1) expired <= 1'b1;
            else                     cnt     <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  rd_err,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        word_len,
    input  logic              bit_tick,
    input  logic              fifo_clr,
    output logic              rts,
    output logic              dma_req,
    output logic              timeout,
    output logic              empty,
    output logic              overrun
);

    rxq_entry_t    din, dout;
    logic [CW-1:0] count;
    logic [CW-1:0] thr;
    logic          above, above_q, to_q, traffic;

    assign din.data = wr_data;
    assign din.err  = wr_err;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (wr_en),
        .pop   (rd_en),
        .din   (din),
        .dout  (dout),
        .count (count),
        .lost  (overrun)
    );

    assign empty   = (count == '0);
    assign traffic = wr_en || (rd_en && !empty);

    rxq_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .clr        (fifo_clr),
        .activity   (traffic),
        .idle_empty (empty),
        .tick       (bit_tick),
        .limit      (idle_limit(word_len)),
        .expired    (timeout)
    );

    assign thr     = CW'(trig_level(trig_sel));
    assign above   = (count >= thr);
    assign rts     = !above;
    assign rd_data = dout.data;
    assign rd_err  = dout.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            above_q <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            above_q <= above;
            to_q    <= timeout;
        end
    end

    assign dma_req = (above && !above_q) || (timeout && !to_q);

endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic rd_en,
    input logic fifo_clr,
    input logic rts,
    input logic dma_req,
    input logic timeout,
    input logic empty,
    input logic overrun
);

    // R3
    empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> rts);

    // R9
    no_stale_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !timeout);

    // R5
    rts_drop_request_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rts) |-> dma_req);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !fifo_clr) |=> overrun);

    // R12
    clear_result_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (empty && !overrun && !timeout));

    // R11
    traffic_clears_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en || (rd_en && !empty)) |=> !timeout);

endmodule

bind rx_trig_fifo rx_trig_fifo_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .fifo_clr (fifo_clr),
    .rts      (rts),
    .dma_req  (dma_req),
    .timeout  (timeout),
    .empty    (empty),
    .overrun  (overrun)
);

// File: tb/rx_trig_fifo_tb.sv
module rx_trig_fifo_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, bit_tick = 1'b0, fifo_clr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_err = '0;
    logic [1:0] trig_sel = '0, word_len = '0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic       rts, dma_req, timeout, empty, overrun;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_trig_fifo u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .trig_sel(trig_sel),
        .word_len(word_len), .bit_tick(bit_tick), .fifo_clr(fifo_clr),
        .rts(rts), .dma_req(dma_req), .timeout(timeout), .empty(empty), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic do_write(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk); wr_en = 1'b1; wr_data = d; wr_err = e;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] d, output logic [2:0] e);
        @(negedge clk); d = rd_data; e = rd_err; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic do_clear();
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        logic [2:0] e;
        int thr, lim, rem;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 empty", empty, 1);
        chk_eq("R1 rts", rts, 1);
        chk_eq("R1 dma_req", dma_req, 0);
        chk_eq("R1 timeout", timeout, 0);
        chk_eq("R1 overrun", overrun, 0);

        // threshold sweep over every select code
        for (int ts = 0; ts < 4; ts++) begin
            thr = (ts == 0) ? 1 : (ts == 1) ? 4 : (ts == 2) ? 8 : 14;
            trig_sel = 2'(ts);
            do_clear();
            for (int i = 1; i <= 16; i++) begin
                do_write(8'(ts * 16 + i), 3'(i % 8));
                chk_eq("R3 rts vs threshold", rts, (i < thr) ? 1 : 0);
                chk_eq("R5 dma pulse on threshold", dma_req, (i == thr) ? 1 : 0);
                chk_eq("R8 empty after write", empty, 0);
                @(negedge clk);
                chk_eq("R5 dma single cycle", dma_req, 0);
            end
            chk_eq("R7 no overrun at 16", overrun, 0);
            do_write(8'hEE, 3'd7);
            chk_eq("R7 overrun on full write", overrun, 1);
            for (int i = 1; i <= 16; i++) begin
                do_read(d, e);
                chk_eq("R2 R6 data order", d, ts * 16 + i);
                chk_eq("R2 error flags", e, i % 8);
                rem = 16 - i;
                chk_eq("R4 rts after read", rts, (rem < thr) ? 1 : 0);
                chk_eq("R8 empty after read", empty, (rem == 0) ? 1 : 0);
            end
            chk_eq("R7 overrun sticky", overrun, 1);
            do_read(d, e);
            chk_eq("R8 read on empty", empty, 1);
            do_write(8'hA5, 3'd2);
            do_read(d, e);
            chk_eq("R8 pointer kept after empty read", d, 8'hA5);
            chk_eq("R8 flags after empty read", e, 2);
        end

        // timeout sweep over every word length
        trig_sel = 2'd3;
        for (int wl = 0; wl < 4; wl++) begin
            word_len = 2'(wl);
            lim = 4 * (5 + wl + 2);
            do_clear();
            do_write(8'h3C, 3'd0);
            do_tick(lim - 1);
            chk_eq("R9 no timeout one tick early", timeout, 0);
            do_tick(1);
            chk_eq("R9 timeout at limit", timeout, 1);
            chk_eq("R10 dma on timeout", dma_req, 1);
            @(negedge clk);
            chk_eq("R10 dma single cycle", dma_req, 0);
            chk_eq("R9 timeout held", timeout, 1);
            if (wl % 2 == 0) begin
                do_read(d, e);
                chk_eq("R11 read clears timeout", timeout, 0);
            end else begin
                do_write(8'h11, 3'd1);
                chk_eq("R11 write clears timeout", timeout, 0);
                do_tick(lim - 1);
                chk_eq("R11 count restarted", timeout, 0);
                do_tick(1);
                chk_eq("R11 timeout again", timeout, 1);
            end
        end

        // no timeout while empty
        do_clear();
        do_tick(50);
        chk_eq("R9 no timeout when empty", timeout, 0);

        // clear wins over write, resets flags
        word_len = 2'd0;
        for (int i = 0; i < 17; i++) do_write(8'(i), 3'd0);
        do_tick(28);
        chk_eq("R9 timeout before clear", timeout, 1);
        chk_eq("R7 overrun before clear", overrun, 1);
        @(negedge clk); fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk); fifo_clr = 1'b0; wr_en = 1'b0;
        chk_eq("R12 empty after clear", empty, 1);
        chk_eq("R12 overrun cleared", overrun, 0);
        chk_eq("R12 timeout cleared", timeout, 0);
        chk_eq("R12 rts after clear", rts, 1);

        done = 1;
        finish_run();
    end

endmodule